// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit collects the event pulses produced by a memory-card host controller's command path, data path, FIFO and card-detect logic and keeps each one in a sticky raw status bit. Software picks, through a mask register, which raw bits may take part in interrupting. The masked status is the bitwise AND of the raw and mask registers. A single interrupt line is raised from the masked status only while the global interrupt enable is set.

Software acknowledges events by writing ones to the raw status, and a zero leaves a bit alone. When an event pulse and an acknowledge hit the same bit in the same cycle, the event wins, so a fresh event is never lost. Two polled summaries, one for errors and one for completion, are formed from the masked status so that a sequencer can decide whether to finish a transfer without decoding every bit.

The asynchronous active-low reset is released synchronously: the state leaves reset on the second rising clock edge after `rst_ni` goes high.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset the raw, mask and masked status all read zero, both summaries are low and `irq_o` is low.
- R2: An event pulse on an implemented bit sets that raw bit on the next clock edge, and the bit then stays set. The implemented bits are 1 to 16, 30 and 31 (constant 0xC001FFFE). Pulses on bits 0, 17 to 29 have no effect, and those raw bits always read zero.
- R3: A cycle with `clr_we_i` high clears every raw bit whose `wdata_i` bit is one and that has no event in the same cycle. Raw bits whose `wdata_i` bit is zero keep their value.
- R4: When an event pulse and an acknowledge hit the same bit in the same cycle, that bit is set after the edge.
- R5: A cycle with `mask_we_i` high loads the mask from `wdata_i`. Only the implemented bits are kept, and the others read zero. `masked_o` always equals `raw_o & mask_o`.
- R6: `error_any_o` is the OR of the masked bits 1, 6, 7, 8, 9, 11, 12, 13 and 15 (constant 0x0000BBC2).
- R7: `done_any_o` is the OR of the masked bits 2, 3, 10 and 14 (constant 0x0000440C).
- R8: `irq_o` is registered. After each clock edge it equals the global enable ANDed with the OR of all masked bits, both taken as they were before that edge.
- R9: A cycle with `ctrl_we_i` high loads the global enable from `wdata_i` bit 4, and all other bits of `wdata_i` are ignored by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| event_i | input | 32 | One-cycle event pulses, one per status bit |
| clr_we_i | input | 1 | Write-one-to-clear strobe for raw status |
| mask_we_i | input | 1 | Mask register write strobe |
| ctrl_we_i | input | 1 | Global control write strobe (enable in bit 4) |
| wdata_i | input | 32 | Write data shared by the three strobes |
| raw_o | output | 32 | Raw sticky status |
| mask_o | output | 32 | Mask register |
| masked_o | output | 32 | Raw status ANDed with mask |
| error_any_o | output | 1 | OR of the masked error group |
| done_any_o | output | 1 | OR of the masked completion group |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A behavioural reference model runs alongside the block and every output is compared after every edge. The directed patterns come first:
- Single events on implemented bits and on unimplemented bits separate the sticky behaviour from the ignored positions.
- Acknowledges with partial write masks show that zeros preserve bits.
- An event and an acknowledge on the same bit in the same cycle isolate the set-over-clear priority.
- Enable writes that carry ones everywhere except bit 4 show that only the enable bit matters.
- Error-only and done-only events confirm that the two summary groups do not overlap.

A long stretch of sparse random events, acknowledges, mask writes and enable writes then exercises the interleavings, including the one-cycle lag of the interrupt line.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int unsigned STAT_W     = 32;
  localparam int unsigned EN_POS     = 4;
  localparam logic [STAT_W-1:0] IMPL_BITS = 32'hC001_FFFE;
  localparam logic [STAT_W-1:0] ERR_BITS  = 32'h0000_BBC2;
  localparam logic [STAT_W-1:0] DONE_BITS = 32'h0000_440C;
endpackage

// File: rtl/sdh_irq_raw.sv
module sdh_irq_raw #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] evt_g;
  logic [W-1:0] clr_g;

  always_comb begin
    evt_g = event_i & IMPL;
    clr_g = clr_data_i & IMPL & {W{clr_we_i}};
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic upd;
      logic nxt;
      logic q;
      always_comb begin
        upd = evt_g[b] | clr_g[b];
        nxt = evt_g[b];            // set has priority over clear
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= 1'b0;
        else if (upd) q <= nxt;
      end
      assign raw_o[b] = q;
    end else begin : g_tie
      assign raw_o[b] = 1'b0;
    end
  end

  assert_unimpl_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o & ~IMPL) == '0);
  assert_event_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(event_i & IMPL)) |=> ((raw_o & $past(event_i & IMPL)) == $past(event_i & IMPL)));
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((raw_o & $past(clr_data_i & ~event_i)) == '0));
endmodule

// File: rtl/sdh_irq_cfg.sv
module sdh_irq_cfg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1,
  parameter int unsigned EN_POS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic         ctrl_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic         en_o
);
  logic [W-1:0] mask_d, mask_q;
  logic         en_d, en_q;

  always_comb begin
    mask_d = wdata_i & IMPL;
    en_d   = wdata_i[EN_POS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= en_d;
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;

  assert_en_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(en_o));
  assert_mask_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == ($past(wdata_i) & IMPL)));
endmodule

// File: rtl/sdh_irq_sum.sv
module sdh_irq_sum #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] ERR = '0,
  parameter logic [W-1:0] DONE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic [W-1:0] masked_o,
  output logic         error_any_o,
  output logic         done_any_o,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    masked_o    = raw_i & mask_i;
    error_any_o = |(masked_o & ERR);
    done_any_o  = |(masked_o & DONE);
    irq_d       = en_i & (|masked_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_masked_in_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~mask_i) == '0);
  assert_err_needs_raw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_any_o |-> (|raw_i));
  assert_done_needs_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_any_o |-> (|raw_i));
  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] event_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic              ctrl_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              error_any_o,
  output logic              done_any_o,
  output logic              irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sdh_irq_raw #(.W(STAT_W), .IMPL(IMPL_BITS)) u_raw (
    .clk_i(clk_i), .rst_ni(rst_n), .event_i(event_i),
    .clr_we_i(clr_we_i), .clr_data_i(wdata_i), .raw_o(raw_o));

  sdh_irq_cfg #(.W(STAT_W), .IMPL(IMPL_BITS), .EN_POS(EN_POS)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .mask_we_i(mask_we_i),
    .ctrl_we_i(ctrl_we_i), .wdata_i(wdata_i), .mask_o(mask_o), .en_o(en));

  sdh_irq_sum #(.W(STAT_W), .ERR(ERR_BITS), .DONE(DONE_BITS)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_n), .raw_i(raw_o), .mask_i(mask_o),
    .en_i(en), .masked_o(masked_o), .error_any_o(error_any_o),
    .done_any_o(done_any_o), .irq_o(irq_o));
endmodule

// File: tb/sdh_irq_status_tb.sv
module sdh_irq_status_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] M_IMPL = 32'hC001_FFFE;
  localparam logic [31:0] M_ERR  = 32'h0000_BBC2;
  localparam logic [31:0] M_DONE = 32'h0000_440C;

  logic clk = 1'b0;
  logic rst_ni;
  logic [31:0] event_i, wdata_i;
  logic clr_we_i, mask_we_i, ctrl_we_i;
  logic [31:0] raw_o, mask_o, masked_o;
  logic error_any_o, done_any_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_raw, m_mask;
  logic m_en, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_irq_status dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i), .clr_we_i(clr_we_i),
    .mask_we_i(mask_we_i), .ctrl_we_i(ctrl_we_i), .wdata_i(wdata_i),
    .raw_o(raw_o), .mask_o(mask_o), .masked_o(masked_o),
    .error_any_o(error_any_o), .done_any_o(done_any_o), .irq_o(irq_o));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] mm;
    mm = m_raw & m_mask;
    chk("R2/R3/R4 raw", raw_o, m_raw);
    chk("R5 mask", mask_o, m_mask);
    chk("R5 masked", masked_o, mm);
    chk("R6 error_any", {31'd0, error_any_o}, {31'd0, |(mm & M_ERR)});
    chk("R7 done_any", {31'd0, done_any_o}, {31'd0, |(mm & M_DONE)});
    chk("R8 irq", {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic step(logic [31:0] ev, logic cw, logic mw, logic tw, logic [31:0] wd);
    logic nirq;
    @(negedge clk);
    compare_all();
    event_i = ev; clr_we_i = cw; mask_we_i = mw; ctrl_we_i = tw; wdata_i = wd;
    nirq = m_en & (|(m_raw & m_mask));
    if (cw) m_raw = m_raw & ~wd;
    m_raw = m_raw | (ev & M_IMPL);
    if (mw) m_mask = wd & M_IMPL;
    if (tw) m_en = wd[4];
    m_irq = nirq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    event_i = '0; wdata_i = '0; clr_we_i = 0; mask_we_i = 0; ctrl_we_i = 0;
    m_raw = '0; m_mask = '0; m_en = 0; m_irq = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 raw", raw_o, 32'd0);
    chk("R1 mask", mask_o, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    // R2: implemented bit sets, unimplemented ignored
    step(32'h0000_0004, 0, 0, 0, 0);
    step(32'h2002_0001, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R5: mask all ones keeps only implemented bits
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    // R6 / R7 groups
    step(32'h0000_0080, 0, 0, 0, 0);
    step(32'h0000_4000, 0, 0, 0, 0);
    // R3: partial clear, then full clear
    step(0, 1, 0, 0, 32'h0000_0004);
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'hFFFF_FFFF);
    // R4: set wins over same-cycle clear
    step(32'h0000_0200, 1, 0, 0, 32'h0000_0200);
    step(0, 0, 0, 0, 0);
    // R9: control write without bit 4 leaves irq low
    step(0, 0, 0, 1, 32'hFFFF_FFEF);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R8: enable -> irq one cycle later, mask off -> irq drops
    step(0, 0, 0, 1, 32'h0000_0010);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 32'h0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // random interleavings across R2..R9
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev, wd;
      logic cw, mw, tw;
      ev = $urandom & $urandom & $urandom & $urandom;
      wd = $urandom;
      cw = ($urandom % 4) == 0;
      mw = ($urandom % 16) == 0;
      tw = ($urandom % 16) == 0;
      step(ev, cw, mw, tw, wd);
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule